// File: doc/BRIEF.md
# Receive Checksum-Offload Statistics Counter Bank

This block keeps running totals of receive checksum-offload events. It has fourteen frame counters and fourteen octet counters, one of each per event kind. Kind index k runs in this order: IPv4 good, IPv4 header error, IPv4 no payload, IPv4 fragmented, IPv4 with UDP checksum disabled, IPv6 good, IPv6 header error, IPv6 no payload, UDP good, UDP error, TCP good, TCP error, ICMP good, ICMP error. A frame counter advances by one on each event pulse. An octet counter adds the byte count that arrives with its pulse.

Each counter has a sticky status bit. The bit is set when the counter passes half of full scale, and again when it passes full scale. A control input chooses whether a counter wraps past full scale or stops at all-ones. Software reads counters and the status word through a read port with byte-lane strobes. A read that includes byte lane 0 of a counter clears that counter's status bit. An interrupt output is high while any status bit is set.

Top module: `ckstat_bank`

## Requirements
- R1: After a synchronous reset, all counters, all status bits, the read data and `irq` are zero.
- R2: A frame counter advances by exactly one per event. An octet counter advances by its 16-bit byte count. Without an event a counter keeps its value. Word index k reads frame counter k and word index 16+k reads octet counter k, zero-extended to 32 bits.
- R3: A counter of width W sets its status bit when an update takes it from below 2^(W-1) to at or above 2^(W-1), including an add that jumps past that value.
- R4: A counter sets its status bit when an update makes it all-ones, or when an add carries past all-ones.
- R5: With `stopRollover` low, an add that carries past all-ones leaves the counter holding the remainder modulo 2^W.
- R6: With `stopRollover` high, an add that would carry past all-ones leaves the counter at all-ones and still sets its status bit. This includes an increment of a counter that already holds all-ones.
- R7: A read of a counter's word index with strobe bit 0 set clears that counter's status bit. A read without strobe bit 0 leaves the bit unchanged.
- R8: If a clearing read and a threshold event hit the same counter in the same cycle, the status bit ends up set. The read returns the value before the increment.
- R9: Word index 32 returns the status word. Frame kind k sits at bit k (bits 0 to 13) and octet kind k at bit 16+k (bits 16 to 29). Bits 14, 15, 30 and 31 read zero. Reading the status word clears nothing.
- R10: Read data appears on `rdData` one cycle after `rdEn`. Byte lane b (bits 8b+7:8b) carries data only when strobe bit b is set, and is zero otherwise. `rdData` is zero in a cycle after no read.
- R11: `irq` is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stopRollover | input | 1 | 1: counters saturate at all-ones; 0: counters wrap |
| frmEvt | input | 14 | Per-kind frame event pulses |
| octEvt | input | 14 | Per-kind octet event pulses |
| octBytes | input | 224 | Byte count for each kind, 16 bits per kind, kind k in bits 16k+15:16k |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 6 | Word index to read |
| rdStrb | input | 4 | Byte-lane enables for the read |
| rdData | output | 32 | Registered read data |
| irq | output | 1 | OR of all status bits |

## Verification
Several cases are hard to reach from the ports: hitting full scale exactly, carrying past it in one large add, and a clearing read that lands in the same cycle as the event that crosses a threshold. The bench narrows the counters through parameters so these values are reachable. It drives a table of octet adds that lands on half scale exactly, lands on full scale exactly, jumps past both, and wraps. A frame counter is then walked to one step below half scale, and the final event is issued together with a clearing read of the same counter.

// File: rtl/ckstat_pkg.sv
package ckstat_pkg;
  localparam int KINDS    = 14;
  localparam int ADDR_W   = 6;
  localparam int BYTE_W   = 16;
  localparam int OCT_BASE = 16;
  localparam int STAT_IDX = 32;
  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;

  typedef struct packed {
    logic              rdFire;
    logic [ADDR_W-1:0] rdIdx;
    logic [LANES-1:0]  rdLanes;
    logic [KINDS-1:0]  clrFrm;
    logic [KINDS-1:0]  clrOct;
  } ctrlStrb_t;
endpackage

// File: rtl/ckstat_ctrl.sv
module ckstat_ctrl
  import ckstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [LANES-1:0]  rdStrb,
  output ctrlStrb_t         strb
);
  always_comb begin
    strb         = '0;
    strb.rdFire  = rdEn;
    strb.rdIdx   = rdAddr;
    strb.rdLanes = rdStrb;
    if (rdEn && rdStrb[0]) begin
      for (int k = 0; k < KINDS; k++) begin
        if (rdAddr == ADDR_W'(k))            strb.clrFrm[k] = 1'b1;
        if (rdAddr == ADDR_W'(OCT_BASE + k)) strb.clrOct[k] = 1'b1;
      end
    end
  end

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.clrOct, strb.clrFrm})); // R7
endmodule

// File: rtl/ckstat_lane.sv
module ckstat_lane #(
  parameter int W     = 32,
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sat,
  input  logic             evt,
  input  logic [INC_W-1:0] inc,
  input  logic             clr,
  output logic [W-1:0]     cnt,
  output logic             flag
);
  localparam int SW = ((W > INC_W) ? W : INC_W) + 1;
  localparam logic [W-1:0] ALL1 = '1;

  logic [SW-1:0] sum;
  logic [W-1:0]  low;
  logic          ov, halfX, fullX, hit;

  always_comb begin
    sum   = SW'(cnt) + SW'(inc);
    low   = sum[W-1:0];
    ov    = |sum[SW-1:W];
    halfX = !cnt[W-1] && low[W-1];
    fullX = (low == ALL1) && (cnt != ALL1);
    hit   = evt && (ov || fullX || halfX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (evt) cnt <= (ov && sat) ? ALL1 : low;
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sat && evt && cnt == ALL1) |=> (cnt == ALL1)); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (hit && clr) |=> flag); // R8
  AST_CLR_DROP: assert property (@(posedge clk) disable iff (rst)
    (clr && !evt) |=> !flag); // R7
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !evt |=> $stable(cnt)); // R2
endmodule

// File: rtl/ckstat_dpath.sv
module ckstat_dpath
  import ckstat_pkg::*;
#(
  parameter int FRM_W = 32,
  parameter int OCT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stopRollover,
  input  logic [KINDS-1:0]        frmEvt,
  input  logic [KINDS-1:0]        octEvt,
  input  logic [KINDS*BYTE_W-1:0] octBytes,
  input  ctrlStrb_t               strb,
  output logic [DATA_W-1:0]       rdData,
  output logic                    irq
);
  localparam logic [DATA_W-1:0] RSVD_MASK = 32'hC000_C000;

  logic [FRM_W-1:0]  frmCnt [KINDS];
  logic [OCT_W-1:0]  octCnt [KINDS];
  logic [KINDS-1:0]  frmFlag, octFlag;
  logic [DATA_W-1:0] statWord, rdMux, laneMask;

  for (genvar k = 0; k < KINDS; k++) begin : g_lane
    ckstat_lane #(.W(FRM_W), .INC_W(1)) u_frm (
      .clk(clk), .rst(rst), .sat(stopRollover), .evt(frmEvt[k]), .inc(1'b1),
      .clr(strb.clrFrm[k]), .cnt(frmCnt[k]), .flag(frmFlag[k]));
    ckstat_lane #(.W(OCT_W), .INC_W(BYTE_W)) u_oct (
      .clk(clk), .rst(rst), .sat(stopRollover), .evt(octEvt[k]),
      .inc(octBytes[k*BYTE_W +: BYTE_W]),
      .clr(strb.clrOct[k]), .cnt(octCnt[k]), .flag(octFlag[k]));
  end

  always_comb begin
    statWord                     = '0;
    statWord[KINDS-1:0]          = frmFlag;
    statWord[OCT_BASE +: KINDS]  = octFlag;
    rdMux = '0;
    if (strb.rdIdx == ADDR_W'(STAT_IDX)) rdMux = statWord;
    for (int k = 0; k < KINDS; k++) begin
      if (strb.rdIdx == ADDR_W'(k))            rdMux = DATA_W'(frmCnt[k]);
      if (strb.rdIdx == ADDR_W'(OCT_BASE + k)) rdMux = DATA_W'(octCnt[k]);
    end
    for (int b = 0; b < LANES; b++) laneMask[b*8 +: 8] = {8{strb.rdLanes[b]}};
  end

  always_ff @(posedge clk) begin
    if (rst)              rdData <= '0;
    else if (strb.rdFire) rdData <= rdMux & laneMask;
    else                  rdData <= '0;
  end

  assign irq = |{frmFlag, octFlag};

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !strb.rdFire |=> (rdData == '0)); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strb.rdFire && strb.rdIdx == ADDR_W'(STAT_IDX)) |=> ((rdData & RSVD_MASK) == '0)); // R9
endmodule

// File: rtl/ckstat_bank.sv
module ckstat_bank
  import ckstat_pkg::*;
#(
  parameter int FRM_W = 32,
  parameter int OCT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stopRollover,
  input  logic [KINDS-1:0]        frmEvt,
  input  logic [KINDS-1:0]        octEvt,
  input  logic [KINDS*BYTE_W-1:0] octBytes,
  input  logic                    rdEn,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [LANES-1:0]        rdStrb,
  output logic [DATA_W-1:0]       rdData,
  output logic                    irq
);
  ctrlStrb_t strb;

  ckstat_ctrl u_ctrl (
    .clk(clk), .rst(rst), .rdEn(rdEn), .rdAddr(rdAddr), .rdStrb(rdStrb), .strb(strb));

  ckstat_dpath #(.FRM_W(FRM_W), .OCT_W(OCT_W)) u_dpath (
    .clk(clk), .rst(rst), .stopRollover(stopRollover), .frmEvt(frmEvt),
    .octEvt(octEvt), .octBytes(octBytes), .strb(strb), .rdData(rdData), .irq(irq));
endmodule

// File: tb/tb_ckstat_bank.sv
module tb_ckstat_bank;
  localparam int FW = 8;
  localparam int OW = 12;
  localparam logic [5:0] STAT = 6'd32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stopRollover = 1'b0;
  logic [13:0] frmEvt = '0;
  logic [13:0] octEvt = '0;
  logic [223:0] octBytes = '0;
  logic        rdEn = 1'b0;
  logic [5:0]  rdAddr = '0;
  logic [3:0]  rdStrb = '0;
  logic [31:0] rdData;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ckstat_bank #(.FRM_W(FW), .OCT_W(OW)) dut (
    .clk(clk), .rst(rst), .stopRollover(stopRollover), .frmEvt(frmEvt),
    .octEvt(octEvt), .octBytes(octBytes), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdStrb(rdStrb), .rdData(rdData), .irq(irq));

  // entry: {bytes[16], expected count[16], expected flag[1]} for octet kind 5
  localparam logic [32:0] VEC [8] = '{
    {16'd100,  16'd100,  1'b0},
    {16'd1900, 16'd2000, 1'b0},
    {16'd48,   16'd2048, 1'b1},
    {16'd1000, 16'd3048, 1'b0},
    {16'd1047, 16'd4095, 1'b1},
    {16'd10,   16'd9,    1'b1},
    {16'd3000, 16'd3009, 1'b1},
    {16'd2000, 16'd913,  1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, input logic [3:0] s, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; rdAddr = a; rdStrb = s;
    @(negedge clk); d = rdData; rdEn = 1'b0;
  endtask

  task automatic octPulse(input int k, input logic [15:0] b);
    @(negedge clk); octEvt[k] = 1'b1; octBytes[k*16 +: 16] = b;
    @(negedge clk); octEvt[k] = 1'b0;
  endtask

  task automatic frmBurst(input int k, input int n);
    @(negedge clk); frmEvt[k] = 1'b1;
    repeat (n) @(negedge clk);
    frmEvt[k] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 rdData", rdData, 32'd0);
    rd(STAT, 4'hF, d); chk("R1 status", d, 32'd0);
    rd(6'd0, 4'hF, d); chk("R1 count", d, 32'd0);

    // table: octet kind 5, wrap mode (R2 R3 R4 R5 R11)
    for (int i = 0; i < 8; i++) begin
      octPulse(5, VEC[i][32:17]);
      rd(STAT, 4'hF, d);
      chk("R3/R4 flag", {31'd0, d[21]}, {31'd0, VEC[i][0]});
      chk("R11 irq", {31'd0, irq}, {31'd0, VEC[i][0]});
      rd(6'd21, 4'hF, d);
      chk("R2/R5 count", d, {16'd0, VEC[i][16:1]});
    end

    // R3 frame half scale, R7 lane-0 rule, R9 layout, R10 lanes
    frmBurst(0, 128);
    octPulse(13, 16'd2048);
    rd(STAT, 4'hF, d); chk("R9 layout", d, 32'h2000_0001);
    rd(STAT, 4'hF, d); chk("R9 no clear", d, 32'h2000_0001);
    rd(6'd0, 4'b0010, d); chk("R10 lane mask", d, 32'd0);
    rd(STAT, 4'hF, d); chk("R7 kept", d, 32'h2000_0001);
    rd(6'd0, 4'b0001, d); chk("R10 lane0", d, 32'd128);
    @(negedge clk); chk("R10 idle zero", rdData, 32'd0);
    rd(6'd29, 4'hF, d); chk("R2 octet 13", d, 32'd2048);
    rd(STAT, 4'hF, d); chk("R7 cleared", d, 32'd0);
    chk("R11 irq low", {31'd0, irq}, 32'd0);

    // R6 saturate mode
    stopRollover = 1'b1;
    frmBurst(13, 128);
    rd(6'd13, 4'hF, d); chk("R2 frame 13", d, 32'd128);
    frmBurst(13, 127);
    rd(STAT, 4'hF, d); chk("R4 full flag", d, 32'h0000_2000);
    rd(6'd13, 4'hF, d); chk("R4 full count", d, 32'd255);
    frmBurst(13, 1);
    rd(STAT, 4'hF, d); chk("R6 flag at ones", d, 32'h0000_2000);
    rd(6'd13, 4'hF, d); chk("R6 held", d, 32'd255);
    octPulse(5, 16'd4000);
    rd(6'd21, 4'hF, d); chk("R6 octet sat", d, 32'd4095);
    rd(STAT, 4'hF, d); chk("R6 octet flag", d, 32'd0);
    stopRollover = 1'b0;

    // R5 frame wrap from all-ones
    frmBurst(13, 1);
    rd(STAT, 4'hF, d); chk("R5 wrap flag", d, 32'h0000_2000);
    rd(6'd13, 4'hF, d); chk("R5 wrap count", d, 32'd0);

    // R8 set wins over clear
    frmBurst(3, 127);
    @(negedge clk); frmEvt[3] = 1'b1; rdEn = 1'b1; rdAddr = 6'd3; rdStrb = 4'hF;
    @(negedge clk); d = rdData; frmEvt[3] = 1'b0; rdEn = 1'b0;
    chk("R8 old value", d, 32'd127);
    rd(STAT, 4'hF, d); chk("R8 set wins", d, 32'h0000_0008);
    chk("R11 irq high", {31'd0, irq}, 32'd1);
    rd(6'd3, 4'hF, d); chk("R8 count", d, 32'd128);
    chk("R11 irq low end", {31'd0, irq}, 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule